// File: doc/BRIEF.md
# Synchronous SRAM with Start-up Selectable Read Timing

This block is a single-port synchronous static memory whose read data can be presented with one of three timings. Address, chip enable, write enable and write data are registered on the rising clock edge. The registered address then reads the storage array combinationally. The output stage delivers that array word in one of three ways. It can register it on the next rising edge. It can latch it on the falling edge that follows the capture. It can also pass it straight through while the registered address is held.

Two static mode pins choose the timing. The block takes their value while reset is held low and keeps it from then on, because the timing must not change during operation. A write stores its data on the same edge that captures it, so a read one cycle later sees the new word. Output enable gates the read port directly, with no clock involved. Reads can be issued on every cycle.

Top module: `ssram_rdproto`

## Requirements
- R1: Mode pins {mode_a, mode_b} decode as follows: 01 is registered (next rising edge), 00 is flow-through, 10 is falling-edge latched, and 11 is reserved. The reserved code behaves as registered and sets mode_err to 1. Every other code leaves mode_err at 0, and mode_err does not change until the next reset.
- R2: The mode is taken from the pins on each clock edge where rst_n is low. After reset is released, changes on the pins have no effect on timing or on mode_err.
- R3: When ce and we are both 1 at a rising edge, wdata is stored at addr on that edge. A read of the same address issued on the next edge returns the new word.
- R4: In registered mode, a read captured at rising edge E gives rvalid=1 and the word after edge E+1. Both are held until edge E+2.
- R5: In falling-edge mode, a read captured at rising edge E gives rvalid=1 and the word after the falling edge that follows E. Both are held until the next falling edge.
- R6: In flow-through mode, a read captured at edge E gives rvalid=1 and the word right after E. Both are held until the next rising edge.
- R7: Reads issued on consecutive edges each return their own word, with no idle cycles between them, in every mode.
- R8: An edge with ce=0, or with ce=1 and we=1, issues no read. At the point where that mode would present read data, rvalid is 0. Whenever rvalid is 0, rdata is 0.
- R9: While oe is 0, rdata is 0 and rvalid is 0, independent of the clock. Raising oe again restores the held read result.
- R10: After reset, rvalid is 0 until a read result is due.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are captured on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; the mode pins are taken while it is low |
| addr | input | AW | Word address |
| ce | input | 1 | Chip enable, registered |
| we | input | 1 | Write enable, registered together with ce |
| wdata | input | DW | Write data |
| oe | input | 1 | Output enable, asynchronous |
| mode_a | input | 1 | Static mode pin, high bit of the mode code |
| mode_b | input | 1 | Static mode pin, low bit of the mode code |
| rdata | output | DW | Read data, 0 when not valid or when oe is low |
| rvalid | output | 1 | Read data valid |
| mode_err | output | 1 | Reserved mode code was seen at reset |

## Verification
The assertions assume that the mode pins are only meaningful while reset is low. They also assume that the bench changes addr, ce, we and wdata only away from the rising edge. To keep within these limits, the stimulus changes inputs a few nanoseconds after each rising edge and sets the pins before reset is asserted. It then deliberately flips the pins after reset is released, to show that the flip has no effect. Array contents are assumed meaningful only after a write, so every mode starts by writing the whole address space before any read is compared.

// File: rtl/ssram_rdproto_pkg.sv
`timescale 1ns/1ps
// Shared types for the selectable-timing SRAM.
// Assumes: mode code {a,b} with 11 reserved.
package ssram_rdproto_pkg;
    typedef enum logic [1:0] {
        PROTO_REG  = 2'd0,   // data after next rising edge
        PROTO_FLOW = 2'd1,   // data straight from array
        PROTO_FALL = 2'd2    // data after next falling edge
    } proto_e;

    // Map the pin pair to a timing; reserved falls back to registered.
    function automatic proto_e decode_mode(input logic pin_a, input logic pin_b);
        case ({pin_a, pin_b})
            2'b00:   return PROTO_FLOW;
            2'b10:   return PROTO_FALL;
            default: return PROTO_REG;
        endcase
    endfunction
endpackage

// File: rtl/ssram_mode_cap.sv
`timescale 1ns/1ps
// Mode capture: follows the pins while reset is low, frozen afterwards.
// Assumes: the pins are static during operation; later changes are ignored.
module ssram_mode_cap
    import ssram_rdproto_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mode_a,
    input  logic   mode_b,
    output proto_e proto,
    output logic   mode_err
);
    // Sample the pins during reset, hold after release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto    <= decode_mode(mode_a, mode_b);
            mode_err <= mode_a & mode_b;
        end
    end

    // R2: timing stays fixed once reset is released.
    a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(proto));
    // R1: the reserved-code flag is sticky until reset.
    a_r1_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err);
endmodule

// File: rtl/ssram_front.sv
`timescale 1ns/1ps
// Input register stage: captures address and read request on the rising edge.
// Assumes: a read is ce high with we low at the capture edge.
module ssram_front #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce,
    input  logic          we,
    output logic [AW-1:0] addr_q,
    output logic          rd_q
);
    // Register the address and the read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rd_q   <= 1'b0;
        end else begin
            addr_q <= addr;
            rd_q   <= ce & ~we;
        end
    end
endmodule

// File: rtl/ssram_array.sv
`timescale 1ns/1ps
// Storage array: writes at the rising edge, combinational read port.
// Assumes: the read address comes from the input register stage.
module ssram_array #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store the word on the capture edge.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Array access modelled as a plain read of the registered address.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/ssram_outstage.sv
`timescale 1ns/1ps
// Output stage: presents the array word on one of three timings.
// Assumes: proto is static after reset; rd_q is a rising-edge register.
module ssram_outstage
    import ssram_rdproto_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  proto_e        proto,
    input  logic          rd_q,
    input  logic [DW-1:0] arr_data,
    output logic          st_valid,
    output logic [DW-1:0] st_data
);
    logic          reg_v, fall_v;
    logic [DW-1:0] reg_d, fall_d;
    logic [DW-1:0] flow_d;

    // Flow-through word: zero when no read is pending.
    always_comb flow_d = rd_q ? arr_data : '0;

    // Registered path: one rising edge after capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_v <= 1'b0;
            reg_d <= '0;
        end else begin
            reg_v <= rd_q;
            reg_d <= flow_d;
        end
    end

    // Falling-edge path: the falling edge after capture.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fall_v <= 1'b0;
            fall_d <= '0;
        end else begin
            fall_v <= rd_q;
            fall_d <= flow_d;
        end
    end

    // Select the path fixed at start-up.
    always_comb begin
        case (proto)
            PROTO_FLOW: begin st_valid = rd_q;   st_data = flow_d; end
            PROTO_FALL: begin st_valid = fall_v; st_data = fall_d; end
            default:    begin st_valid = reg_v;  st_data = reg_d;  end
        endcase
    end

    // R4: a captured read shows up one rising edge later with the array word.
    a_r4_reg_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |=> (reg_v && reg_d == $past(arr_data)));
    // R8: no read at capture means no valid on the registered path.
    a_r8_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_q |=> !reg_v);
endmodule

// File: rtl/ssram_rdproto.sv
`timescale 1ns/1ps
// Top: synchronous SRAM with read timing chosen at reset.
// Assumes: mode pins valid while rst_n is low; oe acts without the clock.
module ssram_rdproto
    import ssram_rdproto_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          oe,
    input  logic          mode_a,
    input  logic          mode_b,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          mode_err
);
    proto_e        proto;
    logic [AW-1:0] addr_q;
    logic          rd_q;
    logic [DW-1:0] arr_data;
    logic          st_valid;
    logic [DW-1:0] st_data;
    logic          wr_en;

    always_comb wr_en = ce & we;

    ssram_mode_cap u_mode (
        .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
        .proto(proto), .mode_err(mode_err)
    );

    ssram_front #(.AW(AW)) u_front (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce(ce), .we(we),
        .addr_q(addr_q), .rd_q(rd_q)
    );

    ssram_array #(.AW(AW), .DW(DW)) u_array (
        .clk(clk), .wr_en(wr_en), .wr_addr(addr), .wr_data(wdata),
        .rd_addr(addr_q), .rd_data(arr_data)
    );

    ssram_outstage #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .proto(proto), .rd_q(rd_q),
        .arr_data(arr_data), .st_valid(st_valid), .st_data(st_data)
    );

    // Asynchronous output enable gate.
    always_comb begin
        rvalid = oe & st_valid;
        rdata  = rvalid ? st_data : '0;
    end

    // R3: a word written at an edge is what the array reads after it.
    a_r3_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && we) |=> arr_data == $past(wdata));
endmodule

// File: tb/test_ssram_rdproto.sv
`timescale 1ns/1ps
module test_ssram_rdproto;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce = 1'b0;
    logic          we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          oe = 1'b1;
    logic          mode_a = 1'b0;
    logic          mode_b = 1'b1;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          mode_err;

    int nvec = 0;
    int nbad = 0;
    int kind = 0;   // 0 registered, 1 flow-through, 2 falling edge
    logic [DW-1:0] model [DEPTH];
    logic          pv;
    logic [DW-1:0] pd;

    ssram_rdproto #(.AW(AW), .DW(DW)) i_ssram_rdproto (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce(ce), .we(we),
        .wdata(wdata), .oe(oe), .mode_a(mode_a), .mode_b(mode_b),
        .rdata(rdata), .rvalid(rvalid), .mode_err(mode_err)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic ev, input logic [DW-1:0] ed);
        nvec++;
        if (rvalid !== ev || rdata !== ed) begin
            nbad++;
            $display("FAIL %s: got v=%0b d=%0h, expected v=%0b d=%0h",
                     req, rvalid, rdata, ev, ed);
        end
    endtask

    // One operation: drive, capture, then check at the timing points.
    task automatic op(input string req, input bit c, input bit w,
                      input int a, input int d);
        logic          ev;
        logic [DW-1:0] ed;
        ce = c; we = w; addr = AW'(a); wdata = DW'(d);
        @(posedge clk);
        ev = c && !w;
        ed = ev ? model[a] : '0;
        if (c && w) model[a] = DW'(d);
        #0.5;
        if (kind == 1) chk(req, ev, ed); else chk(req, pv, pd);
        #2;
        if (kind == 0) chk(req, pv, pd); else chk(req, ev, ed);
        #0.5;
        oe = 1'b0;
        #0.2;
        chk("R9", 1'b0, '0);
        oe = 1'b1;
        #0.1;
        pv = ev;
        pd = ed;
    endtask

    task automatic do_reset(input int m);
        mode_a = m[1];
        mode_b = m[0];
        ce = 1'b0; we = 1'b0; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #0.5;
        chk("R10", 1'b0, '0);
        nvec++;
        if (mode_err !== (m == 3)) begin
            nbad++;
            $display("FAIL R1: mode_err got %0b expected %0b", mode_err, m == 3);
        end
        // R2: flip the pins after release; timing must not follow.
        mode_a = ~mode_a;
        mode_b = ~mode_b;
        pv = 1'b0;
        pd = '0;
    endtask

    initial begin
        // pins {a,b}: 01 registered, 00 flow, 10 falling, 11 reserved
        for (int m = 0; m < 4; m++) begin
            int code;
            string tag;
            code = (m == 0) ? 1 : (m == 1) ? 0 : (m == 2) ? 2 : 3;
            kind = (m == 1) ? 1 : (m == 2) ? 2 : 0;
            tag = (m == 1) ? "R6" : (m == 2) ? "R5" : (m == 3) ? "R1" : "R4";
            do_reset(code);
            for (int a = 0; a < DEPTH; a++)
                op("R3", 1, 1, a, (a * 29 + m * 71 + 5) & 8'hFF);
            for (int a = DEPTH - 1; a >= 0; a--)
                op(tag, 1, 0, a, 0);
            for (int a = 0; a < DEPTH; a++)
                op("R7", 1, 0, (a * 7) % DEPTH, 0);
            for (int a = 0; a < 4; a++) begin
                op("R3", 1, 1, a * 5, (a * 13 + m * 3 + 200) & 8'hFF);
                op("R3", 1, 0, a * 5, 0);
            end
            op("R8", 0, 0, 3, 0);
            op("R8", 1, 0, 3, 0);
            op("R8", 0, 1, 4, 99);
            op("R8", 1, 1, 4, 77);
            op(tag, 1, 0, 4, 0);
            op("R8", 0, 0, 0, 0);
            op("R8", 0, 0, 0, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #800000;
        nbad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule